// File: doc/BRIEF.md
# Pointer Range and Alignment Checker

This block decides, before an indirect call or a dispatch-table load goes ahead, whether a 64-bit target pointer lands on one of the addresses that the call site allows. Each request carries the pointer and a program counter. It also carries a PC-relative region base, a log2 spacing between allowed entries and the highest allowed entry number. It carries an inline membership vector of up to 64 bits, a check mode and a PC-relative failure target. The block answers with exactly one of pass, trap or redirect. A redirect comes with the address of the slow-path handler.

The base is subtracted from the pointer and the difference is rotated right by the spacing amount. Low bits left over by a misaligned pointer wrap into the top of the word. A pointer below the base wraps to a huge value. One unsigned compare against the highest entry number therefore rejects misaligned, low and high pointers together. The rotated value then indexes the membership vector. A single-entry mode replaces all of this with one equality compare, and a dense mode drops the vector lookup.

Requests use a valid/ready handshake. The verdict is registered and is offered on a valid/ready output one cycle after acceptance.

Top module: `ptr_guard`

## Requirements
- R1: The region base and the failure target are each formed as the request PC plus the sign-extended 28-bit offset.
- R2: In every mode except single-entry, a pointer whose distance from the base is not a multiple of 2^shift (shift is 4 bits) fails.
- R3: In every mode except single-entry, an aligned pointer passes the range test only when its entry number, (pointer - base) >> shift, is at most the 20-bit last-entry value. Pointers below the base fail.
- R4: Mode 1 (wide vector) additionally requires vector bit [entry number] to be 1. Entry numbers of 64 or more fail.
- R5: Mode 0 (narrow vector) uses only vector bits 31:0. An entry number of 32 or more fails, even if the upper vector bits are set.
- R6: Mode 2 (single entry) passes exactly when the pointer equals the base. Shift, last-entry and vector are ignored.
- R7: Mode 3 (dense) passes on the range and alignment tests alone. The vector is ignored.
- R8: A failed check with a failure offset of zero reports trap, and the target output is zero.
- R9: A failed check with a nonzero failure offset reports redirect, and the target output is PC + sext(failure offset).
- R10: The one-hot verdict {pass, trap, redirect} becomes valid on the cycle after a request is accepted. On pass, the target output is zero.
- R11: While a verdict is valid and not accepted, the verdict and target stay unchanged and req_ready is low.
- R12: After reset, rsp_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_pc | input | 64 | PC that the offsets are relative to |
| req_ptr | input | 64 | Pointer under test |
| req_base_off | input | 28 | Signed region base offset |
| req_shift | input | 4 | log2 of the entry spacing |
| req_last | input | 20 | Highest allowed entry number |
| req_vec | input | 64 | Inline membership vector |
| req_mode | input | 2 | 0 narrow vector, 1 wide vector, 2 single entry, 3 dense |
| req_fail_off | input | 28 | Signed failure target offset; zero selects trap |
| rsp_valid | output | 1 | Verdict valid |
| rsp_ready | input | 1 | Verdict accepted |
| rsp_pass | output | 1 | Pointer allowed |
| rsp_trap | output | 1 | Pointer rejected, trap |
| rsp_redir | output | 1 | Pointer rejected, go to slow path |
| rsp_target | output | 64 | Slow-path address on redirect, else zero |

## Verification
The embedded properties assume that request fields stay stable during the accepting cycle and that req_valid is never unknown after reset. The driver updates all request fields together, on the falling edge, and changes them only once the handshake has completed. The range property relies on the last-entry value being well below the values that misaligned pointers rotate to. The stimulus keeps shift at 15 or less and keeps last-entry within 20 bits, so this always holds. Backpressure is applied on a fixed repeating pattern, so the stall properties see many stalled cycles without any change in the request stream.

// File: rtl/ptr_guard.sv
`timescale 1ns/1ps
module ptr_guard #(
  parameter int ADDR_W  = 64,
  parameter int OFF_W   = 28,
  parameter int SHIFT_W = 4,
  parameter int LAST_W  = 20,
  parameter int VEC_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [ADDR_W-1:0] req_ptr,
  input  logic [OFF_W-1:0]  req_base_off,
  input  logic [SHIFT_W-1:0] req_shift,
  input  logic [LAST_W-1:0] req_last,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic [1:0]        req_mode,
  input  logic [OFF_W-1:0]  req_fail_off,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_pass,
  output logic              rsp_trap,
  output logic              rsp_redir,
  output logic [ADDR_W-1:0] rsp_target
);
  localparam int IDX_W  = $clog2(VEC_W);
  localparam int HALF_W = VEC_W / 2;
  localparam logic [ADDR_W-1:0] WIDE_LIM   = ADDR_W'(VEC_W);
  localparam logic [ADDR_W-1:0] NARROW_LIM = ADDR_W'(HALF_W);
  localparam logic [1:0] M_NARROW = 2'd0;
  localparam logic [1:0] M_WIDE   = 2'd1;
  localparam logic [1:0] M_SINGLE = 2'd2;
  localparam logic [1:0] M_DENSE  = 2'd3;

  logic [ADDR_W-1:0] base, fail_tgt, diff, idx, last_ext;
  logic              in_range, hit_wide, hit_narrow, ok, accept;
  logic [2:0]        verdict;

  assign accept    = req_valid && req_ready;
  assign req_ready = !rsp_valid || rsp_ready;

  assign base     = req_pc + {{(ADDR_W-OFF_W){req_base_off[OFF_W-1]}}, req_base_off};
  assign fail_tgt = req_pc + {{(ADDR_W-OFF_W){req_fail_off[OFF_W-1]}}, req_fail_off};
  assign diff     = req_ptr - base;
  assign idx      = ADDR_W'({diff, diff} >> req_shift);
  assign last_ext = ADDR_W'(req_last);
  assign in_range = idx <= last_ext;

  assign hit_wide   = (idx < WIDE_LIM)   && req_vec[idx[IDX_W-1:0]];
  assign hit_narrow = (idx < NARROW_LIM) && req_vec[idx[IDX_W-2:0]];

  always_comb begin
    case (req_mode)
      M_NARROW: ok = in_range && hit_narrow;
      M_WIDE:   ok = in_range && hit_wide;
      M_SINGLE: ok = req_ptr == base;
      default:  ok = in_range;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      verdict    <= 3'b000;
      rsp_target <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      if (ok) begin
        verdict    <= 3'b001;
        rsp_target <= '0;
      end else if (req_fail_off == '0) begin
        verdict    <= 3'b010;
        rsp_target <= '0;
      end else begin
        verdict    <= 3'b100;
        rsp_target <= fail_tgt;
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_pass  = verdict[0];
  assign rsp_trap  = verdict[1];
  assign rsp_redir = verdict[2];

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_pass, rsp_trap, rsp_redir}));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(verdict) && $stable(rsp_target));

  p_trap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_trap |-> rsp_target == '0);

  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_mode == M_SINGLE && req_ptr != base |=> !rsp_pass);

  p_misalign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_mode != M_SINGLE &&
    ((req_ptr - base) & ((ADDR_W'(1) << req_shift) - ADDR_W'(1))) != '0 |=> !rsp_pass);

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_mode != M_SINGLE && ((req_ptr - base) >> req_shift) > last_ext |=> !rsp_pass);
endmodule

// File: tb/ptr_guard_test.sv
`timescale 1ns/1ps
module ptr_guard_test;
  typedef struct {
    logic [2:0]  res;
    logic [63:0] tgt;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, rsp_ready = 1, stall_en = 0;
  logic [63:0] req_pc = '0, req_ptr = '0, req_vec = '0;
  logic [27:0] req_base_off = '0, req_fail_off = '0;
  logic [3:0]  req_shift = '0;
  logic [19:0] req_last = '0;
  logic [1:0]  req_mode = '0;
  logic req_ready, rsp_valid, rsp_pass, rsp_trap, rsp_redir;
  logic [63:0] rsp_target;
  int checks = 0, errors = 0, cyc = 0;
  exp_t q[$];

  always #4 clk = ~clk;

  ptr_guard uut (.clk, .rst_n, .req_valid, .req_ready, .req_pc, .req_ptr,
    .req_base_off, .req_shift, .req_last, .req_vec, .req_mode, .req_fail_off,
    .rsp_valid, .rsp_ready, .rsp_pass, .rsp_trap, .rsp_redir, .rsp_target);

  function automatic logic [63:0] sx(input logic [27:0] o);
    return {{36{o[27]}}, o};
  endfunction

  task automatic send(input string tag, input logic [63:0] pc, input logic [63:0] ptr,
                      input logic [27:0] boff, input logic [3:0] sh, input logic [19:0] last,
                      input logic [63:0] vec, input logic [1:0] mode, input logic [27:0] foff);
    exp_t e;
    logic [63:0] base, off, ent;
    logic aligned, rng, ok;
    base = pc + sx(boff);
    off = ptr - base;
    aligned = (off % (64'd1 << sh)) == 0;
    ent = off / (64'd1 << sh);
    rng = aligned && ent <= {44'd0, last};
    case (mode)
      2'd0: ok = rng && ent < 32 && vec[ent[4:0]];
      2'd1: ok = rng && ent < 64 && vec[ent[5:0]];
      2'd2: ok = ptr == base;
      default: ok = rng;
    endcase
    e.tag = tag;
    if (ok) begin e.res = 3'b001; e.tgt = '0; end
    else if (foff == 0) begin e.res = 3'b010; e.tgt = '0; end
    else begin e.res = 3'b100; e.tgt = pc + sx(foff); end
    @(negedge clk);
    req_valid = 1; req_pc = pc; req_ptr = ptr; req_base_off = boff; req_shift = sh;
    req_last = last; req_vec = vec; req_mode = mode; req_fail_off = foff;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      cyc++;
      rsp_ready = !(stall_en && (cyc % 3 != 0));
      #1;
      if (rst_n && rsp_valid) begin
        if (!rsp_ready) begin
          checks++;
          if (req_ready !== 1'b0) begin
            errors++;
            $display("FAIL R11 req_ready during stall: actual %b expected 0", req_ready);
          end
        end else if (q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected verdict: actual %b expected none",
                   {rsp_redir, rsp_trap, rsp_pass});
        end else begin
          exp_t e;
          e = q.pop_front();
          checks++;
          if ({rsp_redir, rsp_trap, rsp_pass} !== e.res || rsp_target !== e.tgt) begin
            errors++;
            $display("FAIL %s: actual res %b tgt %h expected res %b tgt %h",
                     e.tag, {rsp_redir, rsp_trap, rsp_pass}, rsp_target, e.res, e.tgt);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #800000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  localparam logic [63:0] PC = 64'h0000_0000_1000_0000;
  localparam logic [63:0] BS = PC + 64'h400;
  localparam logic [63:0] V42 = 64'h0000_0400_0000_0009;

  initial begin : driver
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R12 reset: actual valid %b ready %b expected 0 1", rsp_valid, req_ready);
    end
    rst_n = 1;
    send("R4 entry0 set",      PC, BS,          28'h400, 4'd3, 20'd42, V42, 2'd1, 28'h0);
    send("R4 entry3 set",      PC, BS + 24,     28'h400, 4'd3, 20'd42, V42, 2'd1, 28'h0);
    send("R8 R4 entry1 clear", PC, BS + 8,      28'h400, 4'd3, 20'd42, V42, 2'd1, 28'h0);
    send("R4 entry42 last",    PC, BS + 42*8,   28'h400, 4'd3, 20'd42, V42, 2'd1, 28'h0);
    send("R3 R9 above last",   PC, BS + 43*8,   28'h400, 4'd3, 20'd42, '1,  2'd1, 28'h100);
    send("R2 misaligned",      PC, BS + 4,      28'h400, 4'd3, 20'd42, '1,  2'd1, 28'h100);
    send("R3 below base",      PC, BS - 8,      28'h400, 4'd3, 20'd42, '1,  2'd1, 28'h0);
    send("R9 negative target", PC, BS - 8,      28'h400, 4'd3, 20'd42, '1,  2'd1, 28'hFFFFFF0);
    send("R5 narrow set",      PC, BS + 24,     28'h400, 4'd3, 20'd3,  64'h9, 2'd0, 28'h0);
    send("R5 narrow clear",    PC, BS + 16,     28'h400, 4'd3, 20'd3,  64'h9, 2'd0, 28'h0);
    send("R5 narrow entry33",  PC, BS + 33*8,   28'h400, 4'd3, 20'd40, '1,  2'd0, 28'h0);
    send("R5 narrow entry31",  PC, BS + 31*8,   28'h400, 4'd3, 20'd40, '1,  2'd0, 28'h0);
    send("R6 single equal",    PC, BS,          28'h400, 4'd9, 20'd0,  '0,  2'd2, 28'h0);
    send("R6 single other",    PC, BS + 8,      28'h400, 4'd3, 20'd9,  '1,  2'd2, 28'h0);
    send("R7 dense in range",  PC, BS + 100*16, 28'h400, 4'd4, 20'd100,'0,  2'd3, 28'h0);
    send("R7 dense past last", PC, BS + 101*16, 28'h400, 4'd4, 20'd100,'0,  2'd3, 28'h55);
    send("R2 dense misalign",  PC, BS + 8,      28'h400, 4'd4, 20'd100,'0,  2'd3, 28'h0);
    send("R1 negative base",   PC, PC - 64'h100, 28'hFFFFF00, 4'd0, 20'd0, '0, 2'd3, 28'h0);
    send("R1 shift15",         PC, PC - 64'h100 + 64'h8000, 28'hFFFFF00, 4'd15, 20'd1, 64'h2, 2'd1, 28'h0);
    stall_en = 1;
    for (int i = 0; i < 12; i++)
      send("R11 under stall", PC, BS + (i % 4) * 8, 28'h400, 4'd3, 20'd2, 64'h5, 2'd1, 28'h20);
    @(negedge clk);
    req_valid = 0;
    stall_en = 0;
    repeat (10) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 missing verdicts: actual %0d pending expected 0", q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule